// File: doc/BRIEF.md
# Indexed page-map and configuration register port

This block is the processor-facing register file of a paged memory controller. It answers four consecutive I/O addresses. Two of them reach a bank of 64 sixteen-bit page-mapping registers through an index and a data port. The other two reach seven eight-bit configuration registers in the same way. Each register keeps only its writable bits. Strap inputs and the chip revision are merged into the read value. The full contents of both banks are driven out in parallel to the address-mapping logic, which is outside this block.

Software normally loads the page index with its top bit set and then streams values through the page-data port. The index advances after every access to that port, so a run of consecutive page registers is loaded without reprogramming the index. Configuration registers are reached by writing the configuration index and then the configuration data.

Top module: `pgcfg_port`

## Requirements
- R1: The block decodes only the four addresses BASE_ADDR to BASE_ADDR+3, with BASE_ADDR a multiple of 4. A read anywhere else returns 0xFFFF, and a write anywhere else changes nothing. When io_rd is low, io_rdata is 0xFFFF.
- R2: Offset 2 is the page index, an 8-bit register that reads back as {0xFF, index}. Its low 6 bits select which page register offset 0 reaches. page_regs_o carries register n at bits [16n+15:16n].
- R3: While page-index bit 7 is set, every read or write at offset 0 adds one to the 8-bit index, with byte and word accesses treated alike. The index wraps from 0xFF to 0x00, which clears bit 7 and stops further stepping. With bit 7 clear the index holds.
- R4: A byte write at offset 0 stores {0xFF, data[7:0]} in the selected page register. A word write stores all 16 bits.
- R5: A word read at offset 0 returns the selected page register ORed with 0xF000 when bit 7 of configuration register 4 is 1, and ORed with 0xFC00 when it is 0. A byte read returns {0xFF, low byte}.
- R6: Offset 1 is the configuration index, present only when HAS_CFG_INDEX=1. It reads back as {0xFF, index}, and its low 3 bits select configuration register 0 to 6. Without the index port, offset 1 reads 0xFFFF, writes to it are dropped, and selection stays at register 0. Selection value 7 reads 0xFFFF at offset 3 and ignores writes.
- R7: Configuration register 0 keeps data bits [4:0]. Its bits [7:5] always show strap_size.
- R8: Configuration register 1 keeps the bits under mask 0xBF. Its bit 6 always shows strap_bank.
- R9: Configuration registers 2 and 3 keep all 8 bits. Register 4 keeps only its low nibble, and its high nibble always shows CHIP_REV.
- R10: Configuration register 5 keeps all 8 bits when HAS_SLEEP=1 and only the low nibble otherwise.
- R11: When CHIP_REV=8, configuration register 6 keeps bits [7:1] and bit 0 shows strap_large. For any other revision it reads 0x00.
- R12: Word accesses at offsets 1, 2 and 3 read 0xFFFF and do not write.
- R13: After reset the page index, configuration index and all page registers are 0. Configuration register 0 holds 0x04 in its writable bits, and registers 1, 2, 3 and 5, and the low nibble of 4, are 0. cfg_regs_o carries the read-back view of register n at bits [8n+7:8n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | AW (16) | I/O address of the access |
| io_wr | input | 1 | Write strobe, one cycle per access, never together with io_rd |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| io_wdata | input | 16 | Write data; byte accesses use bits [7:0] |
| io_rdata | output | 16 | Combinational read data for the current access |
| strap_size | input | 3 | Memory-size strap shown in configuration register 0 |
| strap_bank | input | 1 | Bank strap shown in configuration register 1 bit 6 |
| strap_large | input | 1 | Large-memory strap shown in configuration register 6 bit 0 |
| page_regs_o | output | N_PAGE*16 | All page registers, flattened |
| cfg_regs_o | output | N_CFG*8 | Read-back view of all configuration registers |

## Verification
The bench builds three copies side by side. The first has CHIP_REV=8 with both the index port and the sleep option. The second has CHIP_REV=2, an index port and no sleep option. The third has CHIP_REV=1 and no index port. With the first copy's revision the word-read fill is 0xF000, and with the second copy's it is 0xFC00. Only the first copy keeps register 6, and the two copies differ in how much of register 5 they keep. The third copy exercises the missing index port, where every configuration-data access lands on register 0.

// File: rtl/pgcfg_pkg.sv
package pgcfg_pkg;

  // Offsets inside the four-address window
  typedef enum logic [1:0] {
    OFS_PAGE_DATA = 2'd0,
    OFS_CFG_INDEX = 2'd1,
    OFS_PAGE_INDEX = 2'd2,
    OFS_CFG_DATA = 2'd3
  } io_ofs_e;

  // Fill applied on a word read of the page-data port
  function automatic logic [15:0] page_wide_view(input logic [15:0] r, input logic narrow_fill);
    return r | (narrow_fill ? 16'hF000 : 16'hFC00);
  endfunction

  // Bits a configuration register keeps on a write
  function automatic logic [7:0] cfg_keep_mask(input int idx, input bit sleep_opt, input logic [3:0] rev);
    case (idx)
      0: return 8'h1F;
      1: return 8'hBF;
      2, 3: return 8'hFF;
      4: return 8'h0F;
      5: return sleep_opt ? 8'hFF : 8'h0F;
      6: return (rev == 4'd8) ? 8'hFE : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  // Read-back view: stored bits merged with straps and revision
  function automatic logic [7:0] cfg_view(input int idx, input logic [7:0] st, input logic [3:0] rev,
                                          input logic [2:0] s_size, input logic s_bank, input logic s_large);
    case (idx)
      0: return {s_size, st[4:0]};
      1: return {st[7], s_bank, st[5:0]};
      4: return {rev, st[3:0]};
      6: return (rev == 4'd8) ? {st[7:1], s_large} : 8'h00;
      default: return st;
    endcase
  endfunction

endpackage

// File: rtl/pgcfg_page_bank.sv
module pgcfg_page_bank #(
  parameter int N_PAGE = 64,
  parameter int PW = 16,
  parameter int IW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 idx_wr,
  input  logic [IW-1:0]        idx_wdata,
  input  logic                 acc,
  input  logic                 wr,
  input  logic                 wide,
  input  logic [PW-1:0]        wdata,
  output logic [IW-1:0]        pidx,
  output logic [PW-1:0]        sel_word,
  output logic [N_PAGE*PW-1:0] regs_flat
);
  localparam int SW = $clog2(N_PAGE);

  wire [SW-1:0] sel  = pidx[SW-1:0];
  wire          step = acc && pidx[IW-1];

  always_ff @(posedge clk) begin
    if (!rst_n)      pidx <= '0;
    else if (idx_wr) pidx <= idx_wdata;
    else if (step)   pidx <= pidx + 1'b1;
  end

  for (genvar g = 0; g < N_PAGE; g++) begin : g_page
    logic [PW-1:0] r;
    always_ff @(posedge clk) begin
      if (!rst_n) r <= '0;
      else if (wr && sel == SW'(g))
        r <= wide ? wdata : {{(PW-8){1'b1}}, wdata[7:0]};
    end
    assign regs_flat[g*PW +: PW] = r;
  end

  assign sel_word = regs_flat[sel*PW +: PW];
endmodule

// File: rtl/pgcfg_cfg_bank.sv
module pgcfg_cfg_bank
  import pgcfg_pkg::*;
#(
  parameter int N_CFG = 7,
  parameter bit HAS_IDX = 1'b1,
  parameter bit HAS_SLEEP = 1'b1,
  parameter int CHIP_REV = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idx_wr,
  input  logic               data_wr,
  input  logic [7:0]         wdata,
  input  logic [2:0]         strap_size,
  input  logic               strap_bank,
  input  logic               strap_large,
  output logic [7:0]         cidx,
  output logic               sel_valid,
  output logic [7:0]         sel_view,
  output logic [N_CFG*8-1:0] view_flat
);
  localparam logic [3:0] REV4 = 4'(CHIP_REV);

  if (HAS_IDX) begin : g_idx
    always_ff @(posedge clk) begin
      if (!rst_n)      cidx <= '0;
      else if (idx_wr) cidx <= wdata;
    end
  end else begin : g_noidx
    assign cidx = '0;
  end

  for (genvar g = 0; g < N_CFG; g++) begin : g_cfg
    localparam logic [7:0] RST_VAL = (g == 0) ? 8'h04 : 8'h00;
    logic [7:0] st;
    always_ff @(posedge clk) begin
      if (!rst_n) st <= RST_VAL;
      else if (data_wr && cidx[2:0] == 3'(g))
        st <= wdata & cfg_keep_mask(g, HAS_SLEEP, REV4);
    end
    assign view_flat[g*8 +: 8] = cfg_view(g, st, REV4, strap_size, strap_bank, strap_large);
  end

  assign sel_valid = int'(cidx[2:0]) < N_CFG;
  assign sel_view  = sel_valid ? view_flat[cidx[2:0]*8 +: 8] : 8'hFF;
endmodule

// File: rtl/pgcfg_port.sv
module pgcfg_port
  import pgcfg_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [15:0] BASE_ADDR = 16'h01EC,
  parameter int N_PAGE = 64,
  parameter int N_CFG = 7,
  parameter bit HAS_CFG_INDEX = 1'b1,
  parameter bit HAS_SLEEP = 1'b1,
  parameter int CHIP_REV = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        io_addr,
  input  logic                 io_wr,
  input  logic                 io_rd,
  input  logic                 io_wide,
  input  logic [15:0]          io_wdata,
  output logic [15:0]          io_rdata,
  input  logic [2:0]           strap_size,
  input  logic                 strap_bank,
  input  logic                 strap_large,
  output logic [N_PAGE*16-1:0] page_regs_o,
  output logic [N_CFG*8-1:0]   cfg_regs_o
);
  localparam logic [AW-1:0] BASE = AW'(BASE_ADDR);

  // Decode events, named for the checker
  wire       io_hit  = io_addr[AW-1:2] == BASE[AW-1:2];
  wire [1:0] ofs     = io_addr[1:0];
  wire       pg_acc  = io_hit && ofs == OFS_PAGE_DATA && (io_rd || io_wr);
  wire       pg_wr   = io_hit && ofs == OFS_PAGE_DATA && io_wr;
  wire       pidx_wr = io_hit && ofs == OFS_PAGE_INDEX && io_wr && !io_wide;
  wire       cidx_wr = io_hit && ofs == OFS_CFG_INDEX && io_wr && !io_wide;
  wire       cdat_wr = io_hit && ofs == OFS_CFG_DATA && io_wr && !io_wide;

  logic [7:0]  pidx, cidx, sel_view;
  logic [15:0] sel_word;
  logic        sel_valid;

  pgcfg_page_bank #(.N_PAGE(N_PAGE), .PW(16), .IW(8)) u_page (
    .clk(clk), .rst_n(rst_n), .idx_wr(pidx_wr), .idx_wdata(io_wdata[7:0]),
    .acc(pg_acc), .wr(pg_wr), .wide(io_wide), .wdata(io_wdata),
    .pidx(pidx), .sel_word(sel_word), .regs_flat(page_regs_o)
  );

  pgcfg_cfg_bank #(.N_CFG(N_CFG), .HAS_IDX(HAS_CFG_INDEX), .HAS_SLEEP(HAS_SLEEP),
                   .CHIP_REV(CHIP_REV)) u_cfg (
    .clk(clk), .rst_n(rst_n), .idx_wr(cidx_wr), .data_wr(cdat_wr), .wdata(io_wdata[7:0]),
    .strap_size(strap_size), .strap_bank(strap_bank), .strap_large(strap_large),
    .cidx(cidx), .sel_valid(sel_valid), .sel_view(sel_view), .view_flat(cfg_regs_o)
  );

  wire narrow_fill = cfg_regs_o[4*8+7];

  always_comb begin
    io_rdata = 16'hFFFF;
    if (io_rd && io_hit) begin
      case (ofs)
        OFS_PAGE_DATA:  io_rdata = io_wide ? page_wide_view(sel_word, narrow_fill)
                                           : {8'hFF, sel_word[7:0]};
        OFS_CFG_INDEX:  if (!io_wide && HAS_CFG_INDEX) io_rdata = {8'hFF, cidx};
        OFS_PAGE_INDEX: if (!io_wide) io_rdata = {8'hFF, pidx};
        default:        if (!io_wide && sel_valid) io_rdata = {8'hFF, sel_view};
      endcase
    end
  end
endmodule

// File: rtl/pgcfg_chk.sv
module pgcfg_chk #(
  parameter int N_PAGE = 64,
  parameter int N_CFG = 7,
  parameter int CHIP_REV = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 io_rd,
  input logic                 io_hit,
  input logic [15:0]          io_rdata,
  input logic                 pg_acc,
  input logic                 pg_wr,
  input logic                 pidx_wr,
  input logic                 io_wide,
  input logic [7:0]           pidx,
  input logic [2:0]           strap_size,
  input logic [N_PAGE*16-1:0] page_regs_o,
  input logic [N_CFG*8-1:0]   cfg_regs_o
);
  localparam int SW = $clog2(N_PAGE);

  logic          fill_pend;
  logic [SW-1:0] fill_idx;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_pend <= 1'b0;
      fill_idx  <= '0;
    end else begin
      fill_pend <= pg_wr && !io_wide;
      fill_idx  <= pidx[SW-1:0];
    end
  end

  AST_UNDECODED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_hit) |-> io_rdata == 16'hFFFF); // R1
  AST_AUTO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_acc && pidx[7]) |=> pidx == $past(pidx) + 8'd1); // R3
  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pidx_wr && !(pg_acc && pidx[7])) |=> $stable(pidx)); // R3
  AST_BYTE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_pend |-> page_regs_o[{fill_idx, 4'd8} +: 8] == 8'hFF); // R4
  AST_SIZE_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_regs_o[7:5] == strap_size); // R7
  AST_REV_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_regs_o[4*8+4 +: 4] == 4'(CHIP_REV)); // R9

  if (CHIP_REV != 8) begin : g_no_r6
    AST_CFG6_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_regs_o[6*8 +: 8] == 8'h00); // R11
  end
endmodule

bind pgcfg_port pgcfg_chk #(.N_PAGE(N_PAGE), .N_CFG(N_CFG), .CHIP_REV(CHIP_REV)) i_chk (
  .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_hit(io_hit), .io_rdata(io_rdata),
  .pg_acc(pg_acc), .pg_wr(pg_wr), .pidx_wr(pidx_wr), .io_wide(io_wide), .pidx(pidx),
  .strap_size(strap_size), .page_regs_o(page_regs_o), .cfg_regs_o(cfg_regs_o)
);

// File: tb/test_pgcfg_port.sv
`timescale 1ns/1ps
module test_pgcfg_port;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0, io_wdata = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0, io_wide = 1'b0;
  logic [2:0]  strap_size = 3'b101;
  logic        strap_bank = 1'b1, strap_large = 1'b1;

  logic [15:0]   rd_o [3];
  logic [1023:0] pg_o [3];
  logic [55:0]   cf_o [3];

  pgcfg_port #(.CHIP_REV(8), .HAS_CFG_INDEX(1), .HAS_SLEEP(1)) i_pgcfg_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wide(io_wide),
    .io_wdata(io_wdata), .io_rdata(rd_o[0]), .strap_size(strap_size), .strap_bank(strap_bank),
    .strap_large(strap_large), .page_regs_o(pg_o[0]), .cfg_regs_o(cf_o[0]));
  pgcfg_port #(.CHIP_REV(2), .HAS_CFG_INDEX(1), .HAS_SLEEP(0)) i_pgcfg_port_b (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wide(io_wide),
    .io_wdata(io_wdata), .io_rdata(rd_o[1]), .strap_size(strap_size), .strap_bank(strap_bank),
    .strap_large(strap_large), .page_regs_o(pg_o[1]), .cfg_regs_o(cf_o[1]));
  pgcfg_port #(.CHIP_REV(1), .HAS_CFG_INDEX(0), .HAS_SLEEP(0)) i_pgcfg_port_c (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wide(io_wide),
    .io_wdata(io_wdata), .io_rdata(rd_o[2]), .strap_size(strap_size), .strap_bank(strap_bank),
    .strap_large(strap_large), .page_regs_o(pg_o[2]), .cfg_regs_o(cf_o[2]));

  // Per-copy options
  int REVS [3] = '{8, 2, 1};
  int SLP  [3] = '{1, 0, 0};
  int HIDX [3] = '{1, 1, 0};

  // Behavioural model
  int mpage [3][64];
  int mpidx [3];
  int mcidx [3];
  int mcfg  [3][7];

  int  nchk = 0, nfail = 0;
  bit  cmp_on = 1'b0, done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int sel_cfg(input int k);
    return (HIDX[k] != 0) ? mcidx[k] % 8 : 0;
  endfunction

  function automatic int keep(input int k, input int c);
    case (c)
      0: return 31;
      1: return 191;
      2, 3: return 255;
      4: return 15;
      5: return (SLP[k] != 0) ? 255 : 15;
      6: return (REVS[k] == 8) ? 254 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int view(input int k, input int c);
    int s = mcfg[k][c];
    case (c)
      0: return int'(strap_size) * 32 + s % 32;
      1: return (s & 191) + (strap_bank ? 64 : 0);
      4: return REVS[k] * 16 + s % 16;
      6: return (REVS[k] == 8) ? (s & 254) + int'(strap_large) : 0;
      default: return s;
    endcase
  endfunction

  function automatic bit in_win(input int addr);
    return (addr / 4) == (16'h01EC / 4);
  endfunction

  function automatic int mread(input int k, input int addr, input bit wide);
    int off = addr % 4;
    int v;
    if (!in_win(addr)) return 'hFFFF;
    case (off)
      0: begin
        v = mpage[k][mpidx[k] % 64];
        if (wide) return v | ((view(k, 4) >= 128) ? 'hF000 : 'hFC00);
        return 'hFF00 + v % 256;
      end
      1: return (wide || HIDX[k] == 0) ? 'hFFFF : 'hFF00 + mcidx[k];
      2: return wide ? 'hFFFF : 'hFF00 + mpidx[k];
      default: return (wide || sel_cfg(k) == 7) ? 'hFFFF : 'hFF00 + view(k, sel_cfg(k));
    endcase
  endfunction

  function automatic string tagof(input int k, input int addr, input bit wide);
    string t [8] = '{"R7", "R8", "R9", "R9", "R9", "R10", "R11", "R6"};
    if (!in_win(addr)) return "R1";
    if (addr % 4 == 0) return "R5";
    if (wide) return "R12";
    if (addr % 4 == 1) return "R6";
    if (addr % 4 == 2) return "R2";
    return t[sel_cfg(k)];
  endfunction

  task automatic mupdate(input int k, input bit wr, input bit wide, input int addr, input int data);
    int c;
    if (!in_win(addr)) return;
    case (addr % 4)
      0: begin
        if (wr) mpage[k][mpidx[k] % 64] = wide ? (data & 'hFFFF) : 'hFF00 + data % 256;
        if (mpidx[k] >= 128) mpidx[k] = (mpidx[k] + 1) % 256;
      end
      1: if (wr && !wide && HIDX[k] != 0) mcidx[k] = data % 256;
      2: if (wr && !wide) mpidx[k] = data % 256;
      default: if (wr && !wide) begin
        c = sel_cfg(k);
        if (c < 7) mcfg[k][c] = data & keep(k, c);
      end
    endcase
  endtask

  task automatic model_reset();
    for (int k = 0; k < 3; k++) begin
      mpidx[k] = 0;
      mcidx[k] = 0;
      for (int i = 0; i < 64; i++) mpage[k][i] = 0;
      for (int c = 0; c < 7; c++) mcfg[k][c] = 0;
      mcfg[k][0] = 4;
    end
  endtask

  task automatic acc(input bit wr, input bit wide, input int addr, input int data);
    @(negedge clk);
    io_addr = addr[15:0]; io_wdata = data[15:0]; io_wide = wide; io_wr = wr; io_rd = !wr;
    #1;
    if (!wr) for (int k = 0; k < 3; k++) chk(tagof(k, addr, wide), int'(rd_o[k]), mread(k, addr, wide));
    @(posedge clk);
    #1;
    io_wr = 1'b0; io_rd = 1'b0;
    for (int k = 0; k < 3; k++) mupdate(k, wr, wide, addr, data);
  endtask

  // State outputs compared against the model every clock (R2 R4 R13)
  always @(negedge clk) begin
    if (cmp_on) begin
      for (int k = 0; k < 3; k++) begin
        int bad_p = -1, bad_c = -1;
        for (int i = 0; i < 64; i++) if (int'(pg_o[k][i*16 +: 16]) != mpage[k][i] && bad_p < 0) bad_p = i;
        nchk++;
        if (bad_p >= 0) begin
          nfail++;
          $display("FAIL R4 copy%0d page%0d actual=%h expected=%h", k, bad_p,
                   pg_o[k][bad_p*16 +: 16], mpage[k][bad_p]);
        end
        for (int c = 0; c < 7; c++) if (int'(cf_o[k][c*8 +: 8]) != view(k, c) && bad_c < 0) bad_c = c;
        nchk++;
        if (bad_c >= 0) begin
          nfail++;
          $display("FAIL R13 copy%0d cfg%0d actual=%h expected=%h", k, bad_c,
                   cf_o[k][bad_c*8 +: 8], view(k, bad_c));
        end
      end
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    int lfsr = 32'h1ACE5;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cmp_on = 1'b1;
    // R13 reset state
    acc(0, 0, 'h1EE, 0);
    acc(0, 1, 'h1EC, 0);
    chk("R5 rev8 fill", int'(rd_o[0]), 'hF000);
    chk("R5 rev2 fill", int'(rd_o[1]), 'hFC00);
    // R4 byte vs word writes
    acc(1, 0, 'h1EE, 5);
    acc(1, 1, 'h1EC, 'h1234);
    acc(1, 0, 'h1EC, 'h55AB);
    chk("R4 byte write", int'(pg_o[0][5*16 +: 16]), 'hFFAB);
    acc(0, 0, 'h1EC, 0);
    acc(0, 1, 'h1EC, 0);
    // R3 auto increment and wrap
    acc(1, 0, 'h1EE, 'hBE);
    acc(1, 1, 'h1EC, 'hBEEF);
    acc(1, 1, 'h1EC, 'h0102);
    acc(0, 0, 'h1EE, 0);
    chk("R3 index after two steps", int'(rd_o[0]), 'hFFC0);
    acc(0, 1, 'h1EC, 0);
    acc(1, 0, 'h1EE, 'hFF);
    acc(1, 0, 'h1EC, 'h77);
    acc(1, 0, 'h1EC, 'h66);
    acc(0, 0, 'h1EE, 0);
    chk("R3 wrap stops", int'(rd_o[0]), 'hFF00);
    // R6-R11 every config slot, all ones then zero
    for (int c = 0; c < 8; c++) begin
      acc(1, 0, 'h1ED, c);
      acc(1, 0, 'h1EF, 'hFF);
      acc(0, 0, 'h1EF, 0);
      acc(1, 0, 'h1EF, 'h00);
      acc(0, 0, 'h1EF, 0);
      acc(0, 0, 'h1ED, 0);
    end
    // R12 word access to index and config ports
    acc(1, 1, 'h1EE, 'h0033);
    acc(0, 1, 'h1EE, 0);
    acc(1, 1, 'h1ED, 'h0002);
    acc(0, 1, 'h1EF, 0);
    // R1 undecoded neighbours
    acc(1, 1, 'h1E8, 'hAAAA);
    acc(1, 0, 'h1F0, 'h11);
    acc(0, 1, 'h1EB, 0);
    acc(0, 0, 'h1F0, 0);
    // R7 R8 R11 strap changes
    strap_size = 3'b010; strap_bank = 1'b0; strap_large = 1'b0;
    for (int c = 0; c < 7; c++) begin
      acc(1, 0, 'h1ED, c);
      acc(0, 0, 'h1EF, 0);
    end
    // Mixed traffic around the window
    for (int n = 0; n < 600; n++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 'hB4BCD35C : 0);
      acc(lfsr[3], lfsr[4], 'h1EA + (lfsr >> 5) % 8, (lfsr >> 8) & 'hFFFF);
    end
    done = 1'b1;
    report();
  end
endmodule